// File: doc/BRIEF.md
# Interprocessor Event Signalling Fabric

This block lets several processor domains signal one another through a shared bank of broadcast channels. Each domain owns one port instance with a set of local channels. A local channel carries six things: a send trigger, a send mask that selects broadcast channels, a receive mask that listens to broadcast channels, a sticky receive flag, a subscribe setting and a publish setting. When a channel is triggered, its send mask is driven onto the broadcast bank. In the same clock edge, every instance, the sender included, sets the flag of each local channel whose receive mask overlaps the active broadcast bits.

Each instance has its own small register write port and a combinational read port. It also has a level interrupt equal to the OR of its pending bits, where pending is the interrupt enable ANDed with the receive flags. A per-instance publish vector pulses for one cycle on receive events, and an access-error pulse marks writes to channels that do not exist. External event pulses on the shared subscribe bus can trigger sends without any software write.

Register map per instance (word address `a`, channel `n = a[4:0]`): `0x00+n` send trigger, `0x20+n` receive flag, `0x40+n` send mask, `0x60+n` receive mask, `0x80+n` subscribe setting, `0xA0+n` publish setting, `0xC0` interrupt enable, `0xC1` enable-set alias, `0xC2` enable-clear alias, `0xC3` pending (read only).

Top module: `xdom_evt_fabric`

## Requirements
- R1: Writing 1 in bit 0 of address 0x00+n triggers local channel n, which drives every broadcast channel c whose bit c is set in its send mask at 0x40+n. A mask with several bits fans out to all of them.
- R2: Every instance, the sender included, sets the receive flag of local channel i (bit 0 at 0x20+i) when the receive mask at 0x60+i has any bit of the active broadcast set. The flag reads 1 from the cycle after the trigger cycle.
- R3: A send trigger address always reads back as 0.
- R4: A receive flag stays set until a write of 0 to its address. If a receive event and a clearing write reach the same flag in the same cycle, the flag ends set.
- R5: Pending (0xC3) equals interrupt enable AND receive flags. The irq output is high exactly when pending is nonzero, and it follows a flag or enable change from the cycle after the write.
- R6: A write to 0xC0 replaces the interrupt enable. A write to 0xC1 ORs the data into it. A write to 0xC2 clears the bits that are 1 in the data.
- R7: The publish setting at 0xA0+n has bit 31 as enable and low bits as an event index. Each receive event on an enabled channel drives a one-cycle pulse on bit `index` of that instance's publish vector, in the cycle after the trigger.
- R8: The subscribe setting at 0x80+n has bit 31 as enable and low bits as an index. A cycle in which ext_evt[index] is high triggers the send of channel n in that cycle. Pulses on other indices have no effect.
- R9: Triggers in consecutive cycles are not merged. Each produces its own publish pulse, in consecutive cycles.
- R10: A write to a send trigger or subscribe address with n at or above the channel count raises acc_err for one cycle, in the cycle after the write. Such a write starts no broadcast and stores nothing (the address reads 0).
- R11: Sends from several instances in the same cycle are ORed on the broadcast bank.
- R12: After reset, all registers are 0, irq is low, and the publish vectors and acc_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | N_INST | Write strobe, one bit per instance |
| wr_addr | input | 8*N_INST | Write word address per instance |
| wr_data | input | 32*N_INST | Write data per instance |
| rd_addr | input | 8*N_INST | Read word address per instance |
| rd_data | output | 32*N_INST | Combinational read data per instance |
| ext_evt | input | N_EVT | Shared external event pulses for subscriptions |
| pub_evt | output | N_EVT*N_INST | Publish pulse vector per instance |
| irq | output | N_INST | Level interrupt per instance |
| acc_err | output | N_INST | One-cycle pulse on an out-of-range access |

## Verification
A stuck or wrongly decoded mask bit shows up one cycle after a trigger. Either a publish pulse appears on the wrong instance or index, or an expected pulse is missing. A flag that is lost or wrongly held shows on irq in that same next cycle, and on the pending and flag reads right after. Because the bench queues the exact publish, irq and acc_err values for exact cycles, a pulse that is late by one cycle, merged or doubled counts as a mismatch. Scenarios where a clear and an event arrive together, or where an out-of-range write occurs, are read back right after so that a silent state corruption cannot hide.

// File: rtl/fab_pkg.sv
package fab_pkg;
    // Upper address bits select a register bank, lower five pick the channel.
    typedef enum logic [2:0] {
        RG_TASK  = 3'd0,
        RG_FLAG  = 3'd1,
        RG_SMASK = 3'd2,
        RG_RMASK = 3'd3,
        RG_SUB   = 3'd4,
        RG_PUB   = 3'd5,
        RG_CTL   = 3'd6,
        RG_NONE  = 3'd7
    } region_e;

    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int EN_BIT  = 31;

    localparam logic [4:0] CTL_INTEN = 5'd0;
    localparam logic [4:0] CTL_SET   = 5'd1;
    localparam logic [4:0] CTL_CLR   = 5'd2;
    localparam logic [4:0] CTL_PEND  = 5'd3;
endpackage

// File: rtl/fab_route.sv
module fab_route #(
    parameter int N_INST  = 2,
    parameter int N_BCAST = 8
) (
    input  logic [N_INST*N_BCAST-1:0] send_all,
    output logic [N_BCAST-1:0]        bcast
);
    always_comb begin
        bcast = '0;
        for (int i = 0; i < N_INST; i++) begin
            bcast |= send_all[i*N_BCAST +: N_BCAST];
        end
    end
endmodule

// File: rtl/fab_port.sv
module fab_port
    import fab_pkg::*;
#(
    parameter int N_LOCAL = 4,
    parameter int N_BCAST = 8,
    parameter int N_EVT   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    input  logic [N_EVT-1:0]    ext_evt,
    input  logic [N_BCAST-1:0]  bcast_in,
    output logic [N_BCAST-1:0]  send_out,
    output logic [N_EVT-1:0]    pub_evt,
    output logic                irq,
    output logic                acc_err
);
    localparam int IW = (N_EVT > 1) ? $clog2(N_EVT) : 1;

    logic [N_BCAST-1:0] smask_q [N_LOCAL];
    logic [N_BCAST-1:0] rmask_q [N_LOCAL];
    logic               sub_en_q  [N_LOCAL];
    logic [IW-1:0]      sub_idx_q [N_LOCAL];
    logic               pub_en_q  [N_LOCAL];
    logic [IW-1:0]      pub_idx_q [N_LOCAL];
    logic [N_LOCAL-1:0] flag_q, inten_q, pend, trig, hit;
    logic [N_EVT-1:0]   pub_q, pub_nx;
    logic               err_q;

    region_e    wr_reg, rd_reg;
    logic [4:0] wr_idx, rd_idx;
    logic       wr_ok;
    logic       unused_bits;

    assign wr_reg      = region_e'(wr_addr[7:5]);
    assign wr_idx      = wr_addr[4:0];
    assign rd_reg      = region_e'(rd_addr[7:5]);
    assign rd_idx      = rd_addr[4:0];
    assign wr_ok       = int'(wr_idx) < N_LOCAL;
    assign unused_bits = ^wr_data;

    // Trigger sources: software task write or a subscribed external pulse.
    always_comb begin
        trig     = '0;
        send_out = '0;
        for (int n = 0; n < N_LOCAL; n++) begin
            if (wr_en && wr_reg == RG_TASK && int'(wr_idx) == n && wr_data[0])
                trig[n] = 1'b1;
            if (sub_en_q[n] && int'(sub_idx_q[n]) < N_EVT && ext_evt[sub_idx_q[n]])
                trig[n] = 1'b1;
            if (trig[n])
                send_out |= smask_q[n];
        end
    end

    // Receive side: hit on any overlap of the receive mask with the bank.
    always_comb begin
        pub_nx = '0;
        for (int n = 0; n < N_LOCAL; n++) begin
            hit[n] = |(rmask_q[n] & bcast_in);
            if (hit[n] && pub_en_q[n] && int'(pub_idx_q[n]) < N_EVT)
                pub_nx[pub_idx_q[n]] = 1'b1;
        end
    end

    // Configuration registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int n = 0; n < N_LOCAL; n++) begin
                smask_q[n]   <= '0;
                rmask_q[n]   <= '0;
                sub_en_q[n]  <= 1'b0;
                sub_idx_q[n] <= '0;
                pub_en_q[n]  <= 1'b0;
                pub_idx_q[n] <= '0;
            end
            inten_q <= '0;
        end else if (wr_en) begin
            for (int n = 0; n < N_LOCAL; n++) begin
                if (int'(wr_idx) == n) begin
                    case (wr_reg)
                        RG_SMASK: smask_q[n] <= wr_data[N_BCAST-1:0];
                        RG_RMASK: rmask_q[n] <= wr_data[N_BCAST-1:0];
                        RG_SUB: begin
                            sub_en_q[n]  <= wr_data[EN_BIT];
                            sub_idx_q[n] <= wr_data[IW-1:0];
                        end
                        RG_PUB: begin
                            pub_en_q[n]  <= wr_data[EN_BIT];
                            pub_idx_q[n] <= wr_data[IW-1:0];
                        end
                        default: ;
                    endcase
                end
            end
            if (wr_reg == RG_CTL) begin
                case (wr_idx)
                    CTL_INTEN: inten_q <= wr_data[N_LOCAL-1:0];
                    CTL_SET:   inten_q <= inten_q | wr_data[N_LOCAL-1:0];
                    CTL_CLR:   inten_q <= inten_q & ~wr_data[N_LOCAL-1:0];
                    default: ;
                endcase
            end
        end
    end

    // Sticky flags: an event beats a same-cycle software clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
            pub_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            for (int n = 0; n < N_LOCAL; n++) begin
                if (hit[n])
                    flag_q[n] <= 1'b1;
                else if (wr_en && wr_reg == RG_FLAG && int'(wr_idx) == n)
                    flag_q[n] <= wr_data[0];
            end
            pub_q <= pub_nx;
            err_q <= wr_en && (wr_reg == RG_TASK || wr_reg == RG_SUB) && !wr_ok;
        end
    end

    assign pend    = inten_q & flag_q;
    assign irq     = |pend;
    assign pub_evt = pub_q;
    assign acc_err = err_q;

    always_comb begin
        rd_data = '0;
        for (int n = 0; n < N_LOCAL; n++) begin
            if (int'(rd_idx) == n) begin
                case (rd_reg)
                    RG_FLAG:  rd_data[0] = flag_q[n];
                    RG_SMASK: rd_data[N_BCAST-1:0] = smask_q[n];
                    RG_RMASK: rd_data[N_BCAST-1:0] = rmask_q[n];
                    RG_SUB: begin
                        rd_data[EN_BIT] = sub_en_q[n];
                        rd_data[IW-1:0] = sub_idx_q[n];
                    end
                    RG_PUB: begin
                        rd_data[EN_BIT] = pub_en_q[n];
                        rd_data[IW-1:0] = pub_idx_q[n];
                    end
                    default: ;
                endcase
            end
        end
        if (rd_reg == RG_CTL) begin
            if (rd_idx == CTL_PEND)
                rd_data[N_LOCAL-1:0] = pend;
            else if (rd_idx == CTL_INTEN || rd_idx == CTL_SET || rd_idx == CTL_CLR)
                rd_data[N_LOCAL-1:0] = inten_q;
        end
    end

    // R2: every hit leaves its flag set one edge later.
    assert_hit_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> ((flag_q & $past(hit)) == $past(hit)));

    // R6: set alias leaves the written bits enabled.
    assert_set_alias_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_reg == RG_CTL && wr_idx == CTL_SET)
        |=> ((inten_q & $past(wr_data[N_LOCAL-1:0])) == $past(wr_data[N_LOCAL-1:0])));

    // R6: clear alias removes the written bits.
    assert_clr_alias_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_reg == RG_CTL && wr_idx == CTL_CLR)
        |=> ((inten_q & $past(wr_data[N_LOCAL-1:0])) == '0));

    // R5: no enabled bits, no interrupt.
    assert_irq_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (inten_q == '0) |-> !irq);

    // R7: a publish pulse always follows a receive hit.
    assert_pub_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pub_q != '0) |-> $past(|hit));
endmodule

// File: rtl/xdom_evt_fabric.sv
module xdom_evt_fabric #(
    parameter int N_INST  = 2,
    parameter int N_LOCAL = 4,
    parameter int N_BCAST = 8,
    parameter int N_EVT   = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_INST-1:0]     wr_en,
    input  logic [8*N_INST-1:0]   wr_addr,
    input  logic [32*N_INST-1:0]  wr_data,
    input  logic [8*N_INST-1:0]   rd_addr,
    output logic [32*N_INST-1:0]  rd_data,
    input  logic [N_EVT-1:0]      ext_evt,
    output logic [N_EVT*N_INST-1:0] pub_evt,
    output logic [N_INST-1:0]     irq,
    output logic [N_INST-1:0]     acc_err
);
    localparam int SEND_W = N_INST * N_BCAST;

    logic [SEND_W-1:0]  send_all;
    logic [N_BCAST-1:0] bcast;

    fab_route #(.N_INST(N_INST), .N_BCAST(N_BCAST)) u_route (
        .send_all (send_all),
        .bcast    (bcast)
    );

    for (genvar g = 0; g < N_INST; g++) begin : g_port
        fab_port #(.N_LOCAL(N_LOCAL), .N_BCAST(N_BCAST), .N_EVT(N_EVT)) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en[g]),
            .wr_addr  (wr_addr[g*8 +: 8]),
            .wr_data  (wr_data[g*32 +: 32]),
            .rd_addr  (rd_addr[g*8 +: 8]),
            .rd_data  (rd_data[g*32 +: 32]),
            .ext_evt  (ext_evt),
            .bcast_in (bcast),
            .send_out (send_all[g*N_BCAST +: N_BCAST]),
            .pub_evt  (pub_evt[g*N_EVT +: N_EVT]),
            .irq      (irq[g]),
            .acc_err  (acc_err[g])
        );
    end
endmodule

// File: tb/tb_xdom_evt_fabric.sv
module tb_xdom_evt_fabric;
    localparam int NI = 2;
    localparam int NE = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NI-1:0]   wr_en = '0;
    logic [8*NI-1:0] wr_addr = '0;
    logic [32*NI-1:0] wr_data = '0;
    logic [8*NI-1:0] rd_addr = '0;
    logic [32*NI-1:0] rd_data;
    logic [NE-1:0]   ext_evt = '0;
    logic [NE*NI-1:0] pub_evt;
    logic [NI-1:0]   irq, acc_err;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    typedef struct {
        int          when;
        int          kind;   // 0 publish vector, 1 irq, 2 acc_err
        int          inst;
        logic [31:0] val;
        string       req;
    } exp_t;
    exp_t sbq[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    xdom_evt_fabric dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ext_evt(ext_evt), .pub_evt(pub_evt), .irq(irq), .acc_err(acc_err)
    );

    function automatic logic [31:0] observe(input int kind, input int inst);
        case (kind)
            0:       return 32'(pub_evt[inst*NE +: NE]);
            1:       return 32'(irq[inst]);
            default: return 32'(acc_err[inst]);
        endcase
    endfunction

    // Monitor: pops every expectation due in this cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int k = sbq.size() - 1; k >= 0; k--) begin
                if (sbq[k].when == cyc) begin
                    logic [31:0] act;
                    act = observe(sbq[k].kind, sbq[k].inst);
                    checks++;
                    if (act !== sbq[k].val) begin
                        fails++;
                        $display("FAIL %s kind=%0d inst=%0d actual=%h expected=%h",
                                 sbq[k].req, sbq[k].kind, sbq[k].inst, act, sbq[k].val);
                    end
                    sbq.delete(k);
                end
            end
        end
    end

    task automatic expect_nx(input int kind, input int inst, input logic [31:0] v,
                             input string req);
        exp_t e;
        e.when = cyc + 1; e.kind = kind; e.inst = inst; e.val = v; e.req = req;
        sbq.push_back(e);
    endtask

    task automatic drive(input logic we0, input logic [7:0] a0, input logic [31:0] d0,
                         input logic we1, input logic [7:0] a1, input logic [31:0] d1,
                         input logic [NE-1:0] ev);
        @(negedge clk);
        wr_en   = {we1, we0};
        wr_addr = {a1, a0};
        wr_data = {d1, d0};
        ext_evt = ev;
    endtask

    task automatic wr_a(input logic [7:0] a, input logic [31:0] d);
        drive(1'b1, a, d, 1'b0, 8'h0, 32'h0, '0);
    endtask
    task automatic wr_b(input logic [7:0] a, input logic [31:0] d);
        drive(1'b0, 8'h0, 32'h0, 1'b1, a, d, '0);
    endtask
    task automatic idle();
        drive(1'b0, 8'h0, 32'h0, 1'b0, 8'h0, 32'h0, '0);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    task automatic rd_chk(input int inst, input logic [7:0] a, input logic [31:0] exp_v,
                          input string req);
        @(negedge clk);
        rd_addr[inst*8 +: 8] = a;
        #1;
        chk(req, rd_data[inst*32 +: 32], exp_v);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R12: reset state
        chk("R12 irq", 32'(irq), 32'h0);
        chk("R12 pub", 32'(pub_evt), 32'h0);
        chk("R12 err", 32'(acc_err), 32'h0);
        rd_chk(0, 8'hC0, 32'h0, "R12 inten");
        rd_chk(1, 8'h61, 32'h0, "R12 rmask");

        // Configuration
        wr_a(8'h40, 32'h01);          // A ch0 sends on bcast0
        wr_b(8'h61, 32'h01);          // B ch1 listens to bcast0
        wr_a(8'h62, 32'h01);          // A ch2 listens to bcast0 (self)
        wr_b(8'hA1, 32'h8000_0005);   // B ch1 publishes index 5
        wr_b(8'hC1, 32'h2);           // R6 set alias
        wr_a(8'hC0, 32'h4);           // R6 direct write
        idle();
        rd_chk(1, 8'hC0, 32'h2, "R6 set alias");
        rd_chk(0, 8'hC0, 32'h4, "R6 direct write");

        // R1/R2/R5/R7: single send
        wr_a(8'h00, 32'h1);
        expect_nx(0, 1, 32'h20, "R7 publish B");
        expect_nx(0, 0, 32'h00, "R7 no publish A");
        expect_nx(1, 0, 32'h1, "R5 irq A");
        expect_nx(1, 1, 32'h1, "R5 irq B");
        expect_nx(2, 0, 32'h0, "R10 no err");
        idle();
        expect_nx(0, 1, 32'h00, "R7 one-cycle pulse");
        rd_chk(1, 8'h21, 32'h1, "R2 remote flag");
        rd_chk(0, 8'h22, 32'h1, "R2 self flag");
        rd_chk(0, 8'h20, 32'h0, "R2 unmatched flag");
        rd_chk(0, 8'h00, 32'h0, "R3 task reads zero");
        rd_chk(1, 8'hC3, 32'h2, "R5 pending");

        // R4/R5: clear flag
        wr_b(8'h21, 32'h0);
        expect_nx(1, 1, 32'h0, "R5 irq drops on clear");
        idle();
        rd_chk(1, 8'hC3, 32'h0, "R5 pending cleared");

        // R6: clear alias
        wr_a(8'hC2, 32'h4);
        expect_nx(1, 0, 32'h0, "R6 irq after clear alias");
        idle();
        rd_chk(0, 8'hC0, 32'h0, "R6 clear alias");
        rd_chk(0, 8'h22, 32'h1, "R4 flag sticky");

        // R9: back-to-back sends
        wr_a(8'h00, 32'h1);
        expect_nx(0, 1, 32'h20, "R9 first pulse");
        wr_a(8'h00, 32'h1);
        expect_nx(0, 1, 32'h20, "R9 second pulse");
        idle();
        expect_nx(0, 1, 32'h00, "R9 pulses end");

        // R8: subscription
        wr_b(8'h83, 32'h8000_0002);
        wr_b(8'h43, 32'h02);
        wr_a(8'h61, 32'h02);
        wr_a(8'hA1, 32'h8000_0007);
        drive(1'b0, 8'h0, 32'h0, 1'b0, 8'h0, 32'h0, 8'h04);
        expect_nx(0, 0, 32'h80, "R8 subscribed trigger");
        drive(1'b0, 8'h0, 32'h0, 1'b0, 8'h0, 32'h0, 8'h08);
        expect_nx(0, 0, 32'h00, "R8 other index ignored");
        idle();
        rd_chk(0, 8'h21, 32'h1, "R8 flag from subscription");

        // R11: simultaneous sends ORed
        wr_b(8'h60, 32'h02);
        wr_b(8'hA0, 32'h8000_0001);
        drive(1'b1, 8'h00, 32'h1, 1'b1, 8'h03, 32'h1, '0);
        expect_nx(0, 1, 32'h22, "R11 B sees both");
        expect_nx(0, 0, 32'h80, "R11 A sees bcast1");
        idle();

        // R10: out-of-range accesses
        wr_a(8'h04, 32'h1);
        expect_nx(2, 0, 32'h1, "R10 task err");
        expect_nx(0, 1, 32'h0, "R10 no broadcast B");
        expect_nx(0, 0, 32'h0, "R10 no broadcast A");
        idle();
        expect_nx(2, 0, 32'h0, "R10 err one cycle");
        wr_b(8'h84, 32'h8000_0000);
        expect_nx(2, 1, 32'h1, "R10 subscribe err");
        idle();
        rd_chk(1, 8'h84, 32'h0, "R10 nothing stored");

        // R4: event beats same-cycle clear
        drive(1'b1, 8'h00, 32'h1, 1'b1, 8'h21, 32'h0, '0);
        expect_nx(0, 1, 32'h20, "R4 publish on collision");
        idle();
        rd_chk(1, 8'h21, 32'h1, "R4 event wins clear");

        // R1: multi-bit fan-out
        wr_a(8'h40, 32'h03);
        idle();
        wr_a(8'h00, 32'h1);
        expect_nx(0, 1, 32'h22, "R1 fan-out to B");
        expect_nx(0, 0, 32'h80, "R1 fan-out to A");
        idle();
        rd_chk(0, 8'h40, 32'h3, "R1 mask readback");

        repeat (3) @(negedge clk);
        if (sbq.size() != 0) begin
            fails++;
            $display("FAIL scoreboard actual=%0d expected=0 pending items", sbq.size());
        end
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule